// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the local monitor that sits beside one core's load/store unit and decides whether a store-exclusive may reach memory. A load-exclusive request arms a single reservation that records the low 32 bits of its address. A later store-exclusive is compared with that reservation over an 8-byte granule. If it matches, the store goes on to the memory port, the reservation is used up, and the core receives status 0. Otherwise the store is dropped and the core receives status 1. A separate clear request drops the reservation at any time.

Requests arrive on one port: a valid bit, a 2-bit operation, a 64-bit address and a size code, with a clear line beside them. Each store-exclusive gets one registered response with a 32-bit status word. A successful store also produces a one-cycle write strobe that carries the request's address and size code to memory.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is empty, `rsp_valid` and `mem_we` are low and `rsp_status` is 0. A store-exclusive issued before any load-exclusive, including one to address 0, fails.
- R2: A load-exclusive is `req_valid`=1 with `req_op`=2'b01 and a legal size. It arms the reservation with `req_addr[31:0]`. Address bits above bit 31 play no part in matching.
- R3: A store-exclusive is `req_valid`=1 with `req_op`=2'b10. With no reservation held it fails: status is 1 and no write strobe is raised.
- R4: A store whose `req_addr[31:0]` differs from the reserved address in any bit from 3 upward fails with status 1 and no write. A failed store of this kind leaves the reservation armed.
- R5: A matching store returns status 0. It raises `mem_we` for exactly one cycle, with `mem_addr` equal to the request address and `mem_size` equal to the request size code.
- R6: A successful store consumes the reservation, so a second store-exclusive with no new load-exclusive between them fails.
- R7: A cycle with `clr_req`=1 empties the reservation, so the next store-exclusive fails.
- R8: `clr_req` has priority. A load-exclusive in the same cycle does not arm, and a store-exclusive in the same cycle fails.
- R9: Every store-exclusive gets exactly one response: `rsp_valid` is high for one cycle, on the cycle after the request, and `rsp_status` is 0 or 1. Loads, clears and idle cycles produce no response.
- R10: Size code n stands for 2^n bytes, and codes 0 to 4 are legal. A load with code 5, 6 or 7 leaves the reservation unchanged. A store with such a code fails without a write.
- R11: A new load-exclusive replaces the reserved address, so only the most recent address can be stored to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier |
| req_op | input | 2 | 01 load-exclusive, 10 store-exclusive, others no operation |
| req_addr | input | 64 | Access address |
| req_size | input | 3 | Log2 of access size in bytes |
| clr_req | input | 1 | Drop the reservation |
| rsp_valid | output | 1 | Store-exclusive response qualifier |
| rsp_status | output | 32 | 0 = store performed, 1 = store failed |
| mem_we | output | 1 | Write strobe to memory |
| mem_addr | output | 64 | Write address |
| mem_size | output | 3 | Write size code |

## Verification
The cases that are hardest to reach from the ports are those where the reservation state differs from what the address alone would suggest. Examples are a reservation that survives a mismatching store, one left untouched by an illegal-size load, and a clear that lands in the same cycle as a load or a store. The stimulus reaches each of these with short scripted sequences and then probes the state with a follow-up store-exclusive whose status shows whether the reservation was still armed. Back-to-back requests with no idle cycles between them check the one-cycle response timing, and addresses that differ only above bit 31 check that the upper bits play no part in matching.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    localparam int EM_ADDR_W    = 64;
    localparam int EM_RSV_W     = 32;
    localparam int EM_GRAN_LOG2 = 3;
    localparam int EM_STATUS_W  = 32;
    localparam int EM_SIZE_W    = 3;
    localparam int EM_MAX_SIZE  = 4;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LDEX = 2'b01,
        OP_STEX = 2'b10,
        OP_RSVD = 2'b11
    } excl_op_e;

    // decoded request for one cycle
    typedef struct packed {
        logic arm;      // load-exclusive that will set the reservation
        logic store;    // store-exclusive attempt
        logic size_ok;  // size code within the legal range
        logic clear;    // clear request present
    } excl_dec_t;

    function automatic logic size_code_legal(input logic [EM_SIZE_W-1:0] code);
        return (int'(code) <= EM_MAX_SIZE);
    endfunction

endpackage

// File: rtl/excl_rsv_state.sv
module excl_rsv_state #(
    parameter int RSV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             arm,
    input  logic [RSV_W-1:0] arm_addr,
    input  logic             consume,
    output logic             rsv_valid,
    output logic [RSV_W-1:0] rsv_addr
);
    logic             valid_q;
    logic [RSV_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;            // address kept
        end else if (arm) begin
            valid_q <= 1'b1;
            addr_q  <= arm_addr;
        end else if (consume) begin
            valid_q <= 1'b0;
        end
    end

    assign rsv_valid = valid_q;
    assign rsv_addr  = addr_q;
endmodule

// File: rtl/excl_addr_match.sv
module excl_addr_match #(
    parameter int RSV_W     = 32,
    parameter int GRAN_LOG2 = 3
) (
    input  logic             rsv_valid,
    input  logic [RSV_W-1:0] rsv_addr,
    input  logic [RSV_W-1:0] req_addr_lo,
    input  logic             size_ok,
    input  logic             blocked,
    output logic             hit
);
    logic [RSV_W-1:0] gran_mask;
    logic [RSV_W-1:0] diff;

    // bits below the granule are don't-care in the compare
    for (genvar i = 0; i < RSV_W; i++) begin : g_mask
        if (i < GRAN_LOG2) begin : g_lo
            assign gran_mask[i] = 1'b0;
        end else begin : g_hi
            assign gran_mask[i] = 1'b1;
        end
    end

    assign diff = (req_addr_lo ^ rsv_addr) & gran_mask;
    assign hit  = rsv_valid && size_ok && !blocked && (diff == '0);
endmodule

// File: rtl/excl_rsp_gen.sv
module excl_rsp_gen #(
    parameter int ADDR_W   = 64,
    parameter int SIZE_W   = 3,
    parameter int STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                store,
    input  logic                hit,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SIZE_W-1:0]   size,
    output logic                rsp_valid,
    output logic [STATUS_W-1:0] rsp_status,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SIZE_W-1:0]   mem_size
);
    localparam logic [STATUS_W-1:0] STAT_PASS = '0;
    localparam logic [STATUS_W-1:0] STAT_FAIL = STATUS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= STAT_PASS;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_size   <= '0;
        end else begin
            rsp_valid <= store;
            mem_we    <= store && hit;
            if (store) begin
                rsp_status <= hit ? STAT_PASS : STAT_FAIL;
                mem_addr   <= addr;
                mem_size   <= size;
            end
        end
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W    = EM_ADDR_W,
    parameter int RSV_W     = EM_RSV_W,
    parameter int GRAN_LOG2 = EM_GRAN_LOG2,
    parameter int STATUS_W  = EM_STATUS_W,
    parameter int SIZE_W    = EM_SIZE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic                clr_req,
    output logic                rsp_valid,
    output logic [STATUS_W-1:0] rsp_status,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SIZE_W-1:0]   mem_size
);
    excl_dec_t        dec;
    logic             rsv_valid;
    logic [RSV_W-1:0] rsv_addr;
    logic             hit;

    always_comb begin
        dec.clear   = clr_req;
        dec.size_ok = (int'(req_size) <= EM_MAX_SIZE);
        dec.store   = req_valid && (excl_op_e'(req_op) == OP_STEX);
        dec.arm     = req_valid && (excl_op_e'(req_op) == OP_LDEX) && dec.size_ok;
    end

    excl_rsv_state #(.RSV_W(RSV_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .clear     (dec.clear),
        .arm       (dec.arm),
        .arm_addr  (req_addr[RSV_W-1:0]),
        .consume   (dec.store && hit),
        .rsv_valid (rsv_valid),
        .rsv_addr  (rsv_addr)
    );

    excl_addr_match #(.RSV_W(RSV_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
        .rsv_valid   (rsv_valid),
        .rsv_addr    (rsv_addr),
        .req_addr_lo (req_addr[RSV_W-1:0]),
        .size_ok     (dec.size_ok),
        .blocked     (dec.clear),
        .hit         (hit)
    );

    excl_rsp_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .STATUS_W(STATUS_W)) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .store      (dec.store),
        .hit        (hit),
        .addr       (req_addr),
        .size       (req_size),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size)
    );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int STATUS_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_op,
    input logic                clr_req,
    input logic                rsv_valid,
    input logic                rsp_valid,
    input logic [STATUS_W-1:0] rsp_status,
    input logic                mem_we
);
    p_rsp_after_store_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_op == 2'b10));

    p_store_gets_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10) |=> rsp_valid);

    p_status_binary_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status == '0 || rsp_status == STATUS_W'(1)));

    p_we_with_pass_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (rsp_valid && rsp_status == '0));

    p_pass_with_we_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == '0) |-> mem_we);

    p_no_rsv_fails_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && !rsv_valid) |=> (rsp_status == STATUS_W'(1) && !mem_we));

    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_consume_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !rsv_valid);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !rsv_valid);
endmodule

bind excl_monitor excl_monitor_chk #(.STATUS_W(STATUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .clr_req    (clr_req),
    .rsv_valid  (rsv_valid),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .mem_we     (mem_we)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        clr_req = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_status;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [2:0]  mem_size;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        logic [31:0] status;
        logic [63:0] addr;
        logic [2:0]  size;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    // reference model state
    bit          m_valid = 0;
    logic [31:0] m_addr = '0;

    excl_monitor uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .clr_req(clr_req),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic issue(input logic [1:0] op, input logic [63:0] a,
                         input logic [2:0] sz, input bit clr, input string tag);
        bit ok;
        exp_t e;
        @(negedge clk);
        req_valid = (op != 2'b00);
        req_op    = op;
        req_addr  = a;
        req_size  = sz;
        clr_req   = clr;
        if (op == 2'b10) begin
            ok = !clr && m_valid && (sz <= 3'd4) && (((a[31:0] ^ m_addr) & 32'hFFFF_FFF8) == 0);
            e.due = cyc + 1; e.status = ok ? 32'd0 : 32'd1;
            e.addr = a; e.size = sz; e.tag = tag;
            sbq.push_back(e);
        end
        if (clr) m_valid = 0;
        else if (op == 2'b01 && sz <= 3'd4) begin m_valid = 1; m_addr = a[31:0]; end
        else if (op == 2'b10 && ok) m_valid = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_op = 2'b00; clr_req = 0;
    endtask

    task automatic chk(input bit cond, input string msg, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", msg, got, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_valid, {e.tag, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
                chk(rsp_status == e.status, {e.tag, " status"}, 64'(rsp_status), 64'(e.status));
                chk(mem_we == (e.status == 0), {e.tag, " R5 mem_we"}, 64'(mem_we), 64'(e.status == 0));
                if (e.status == 0) begin
                    chk(mem_addr == e.addr, {e.tag, " R5 mem_addr"}, mem_addr, e.addr);
                    chk(mem_size == e.size, {e.tag, " R5 mem_size"}, 64'(mem_size), 64'(e.size));
                end
            end else if (rsp_valid || mem_we) begin
                chk(0, "R9 unexpected response", 64'(rsp_valid), 64'd0);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 0, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
        chk(mem_we == 0, "R1 mem_we in reset", 64'(mem_we), 0);
        chk(rsp_status == 0, "R1 status in reset", 64'(rsp_status), 0);
        rst = 0;
        idle();
        chk(rsp_valid == 0 && mem_we == 0, "R1 idle after reset", 64'(rsp_valid), 0);

        issue(2'b10, 64'h0, 3'd2, 0, "R1");                // reserved addr 0 but empty
        issue(2'b10, 64'h100, 3'd3, 0, "R3");
        idle();
        // R2 arm and match within granule, back to back
        issue(2'b01, 64'h1000_0010, 3'd2, 0, "R2");
        issue(2'b10, 64'h1000_0017, 3'd2, 0, "R2");
        issue(2'b10, 64'h1000_0010, 3'd2, 0, "R6");
        idle();
        // R4 mismatch keeps reservation
        issue(2'b01, 64'h40, 3'd3, 0, "R4");
        issue(2'b10, 64'h48, 3'd3, 0, "R4");
        issue(2'b10, 64'h44, 3'd3, 0, "R4");
        // R2 upper bits ignored
        issue(2'b01, 64'hABCD_0000_0000_2000, 3'd3, 0, "R2");
        issue(2'b10, 64'h1234_0000_0000_2004, 3'd1, 0, "R2");
        // R7 clear
        issue(2'b01, 64'h300, 3'd2, 0, "R7");
        issue(2'b00, 64'h0, 3'd0, 1, "R7");
        issue(2'b10, 64'h300, 3'd2, 0, "R7");
        // R8 clear with load, clear with store
        issue(2'b01, 64'h500, 3'd2, 1, "R8");
        issue(2'b10, 64'h500, 3'd2, 0, "R8");
        issue(2'b01, 64'h600, 3'd2, 0, "R8");
        issue(2'b10, 64'h600, 3'd2, 1, "R8");
        issue(2'b10, 64'h600, 3'd2, 0, "R8");
        idle();
        // R10 size codes
        issue(2'b01, 64'h700, 3'd5, 0, "R10");
        issue(2'b10, 64'h700, 3'd2, 0, "R10");
        issue(2'b01, 64'h800, 3'd4, 0, "R10");
        issue(2'b10, 64'h808, 3'd4, 0, "R10");
        issue(2'b10, 64'h800, 3'd7, 0, "R10");
        issue(2'b10, 64'h800, 3'd4, 0, "R10");
        issue(2'b01, 64'h900, 3'd0, 0, "R10");
        issue(2'b01, 64'hA00, 3'd6, 0, "R10");
        issue(2'b10, 64'h900, 3'd0, 0, "R10");
        // R11 replacement
        issue(2'b01, 64'hB00, 3'd2, 0, "R11");
        issue(2'b01, 64'hC00, 3'd2, 0, "R11");
        issue(2'b10, 64'hB00, 3'd2, 0, "R11");
        issue(2'b10, 64'hC04, 3'd2, 0, "R11");
        idle();
        repeat (3) idle();
        chk(sbq.size() == 0, "R9 all responses seen", 64'(sbq.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule